// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block sits between a set of interrupt sources and a processor core. It watches sixteen maskable request lines and one non-maskable line, latches a pending flag on each rising edge, and on any cycle in which a request may be taken it hands the core one vector index together with a single-cycle request strobe. Maskable lines 0 to 13 are general sources, line 14 is the debug-log source and line 15 is the real-time-OS source. Lines below `NUM_GROUPS` (lines 0 to 11 by default) each stand for a peripheral group and pass through a per-group acknowledge gate. The upper lines have no such gate.

Taking a maskable request makes the block update its own state. It clears that line's enable bit, sets the global mask and closes the group gate, so the handler runs to completion unless software deliberately reopens the enable bit and the mask. Before each entry the enable register and global mask are pushed onto a two-deep shadow stack. An interrupt-return pulse pops the most recent frame and restores both values. The non-maskable line ignores the enable bits, the mask and the group gates. It may therefore interrupt a running maskable handler. A second non-maskable edge is dropped until that handler returns.

Software writes the enable register and the global mask through write strobes, and reopens group gates through per-group clear bits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is presented, every enable bit is 0, the global mask is 1 (masked) and every group gate is open (0).
- R2: A maskable pending flag is set only by a rising edge of its line. A level held high does not raise the flag again. Two edges that arrive while the flag is already pending produce exactly one request.
- R3: A pending maskable line is forwarded only while its enable bit is 1 and the global mask is 0. If it is blocked, the flag stays set and the request is issued once both gates open.
- R4: When several maskable lines are eligible in the same cycle, the lowest-numbered line is taken and the vector equals the line number (0 to 15).
- R5: In the cycle after a maskable request is taken, that line's enable bit reads 0, the global mask reads 1, and for a line below NUM_GROUPS (12) its group gate bit reads 1.
- R6: A closed group gate blocks its own line until software writes 1 to that bit of the acknowledge clear. Other lines, and lines at or above NUM_GROUPS, are not affected by it.
- R7: A lower-numbered maskable request that arrives during a maskable handler stays pending and is taken in the first cycle after the return restores the mask to 0.
- R8: A rising edge of the non-maskable line is forwarded with vector 16 regardless of the enable bits, the mask and the group gates, and it takes precedence over maskable lines. Entry leaves the enable register and mask unchanged.
- R9: Non-maskable edges that arrive while a non-maskable handler is active are discarded. After the return they do not cause a request.
- R10: An interrupt return restores the enable register and global mask saved at the most recent entry, in last-in first-out order. A return with an empty stack changes nothing.
- R11: The request strobe lasts one cycle, with the vector valid in that same cycle. No request is issued in a return cycle or while the shadow stack is full. Software writes to the enable register or mask are ignored in cycles that take a request or assert the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 16 | Maskable request lines, rising edge triggered |
| nmi_lvl_i | input | 1 | Non-maskable request line, rising edge triggered |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 16 | New enable register value |
| mask_we_i | input | 1 | Write strobe for the global mask |
| mask_wdata_i | input | 1 | New global mask value (1 = masked) |
| ack_clr_i | input | 12 | Per-group acknowledge clear; a 1 reopens that group gate |
| iret_i | input | 1 | Interrupt return pulse |
| req_o | output | 1 | One-cycle request strobe to the core |
| vec_o | output | 5 | Vector index: 0 to 15 for maskable lines, 16 for the non-maskable line |
| en_o | output | 16 | Current enable register |
| mask_o | output | 1 | Current global mask |
| ack_o | output | 12 | Group gate state, 1 = closed |

## Verification
The hardest state to reach is a full shadow stack: a maskable handler preempted by a non-maskable one, with software then reopening the mask and enables. The stimulus builds it in order: a maskable entry, then a non-maskable pulse, then register writes. It then offers a maskable edge and a further non-maskable edge, both of which must be held off. Two returns then unwind the stack one frame at a time, and the bench observes the restored enable and mask values after each pop. Only after the second return is the held maskable request expected to come out. Priority is swept over every pair of lines, and entry and exit are swept over every single line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;

  // Vector index width: maskable lines plus one non-maskable code.
  function automatic int unsigned vec_width(input int unsigned lines);
    return $clog2(lines + 1);
  endfunction

  // Width of a line index within the maskable set.
  function automatic int unsigned line_idx_width(input int unsigned lines);
    return (lines > 1) ? $clog2(lines) : 1;
  endfunction

endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] arm,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  logic [N-1:0] lvl_q;
  logic [N-1:0] rise;

  assign rise = lvl & ~lvl_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[k] <= 1'b0;
        pend[k]  <= 1'b0;
      end else begin
        lvl_q[k] <= lvl[k];
        pend[k]  <= (pend[k] & ~clr[k]) | (rise[k] & arm[k]);
      end
    end

    // R2: a pending flag is only removed by an acceptance
    assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[k] && !clr[k]) |=> pend[k]);
  end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
    any   = |req;
    grant = any ? (N'(1) << idx) : '0;
  end

  assert_grant_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4: nothing below the granted line was requesting
  assert_grant_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((req & (grant - N'(1))) == '0));

endmodule

// File: rtl/irqc_ctx_stack.sv
module irqc_ctx_stack
  import irqc_pkg::*;
#(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stk_op_e      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);

  localparam int unsigned SPW = $clog2(DEPTH + 1);

  logic [SPW-1:0] sp;
  logic [W-1:0]   mem [DEPTH];
  logic           do_push;
  logic           do_pop;

  assign empty   = (sp == '0);
  assign full    = (sp == SPW'(DEPTH));
  assign do_push = (op == STK_PUSH) && !full;
  assign do_pop  = (op == STK_POP) && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= '0;
    else if (do_push) sp <= sp + SPW'(1);
    else if (do_pop)  sp <= sp - SPW'(1);
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[k] <= '0;
      else if (do_push && sp == SPW'(k))    mem[k] <= wdata;
    end
  end

  always_comb begin
    top = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sp == SPW'(k + 1)) top = mem[k];
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH) |-> !full);

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP) |-> !empty);

  assert_sp_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned NUM_GROUPS  = 12,
  parameter int unsigned STACK_DEPTH = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_LINES-1:0]                 irq_lvl_i,
  input  logic                                 nmi_lvl_i,
  input  logic                                 en_we_i,
  input  logic [NUM_LINES-1:0]                 en_wdata_i,
  input  logic                                 mask_we_i,
  input  logic                                 mask_wdata_i,
  input  logic [NUM_GROUPS-1:0]                ack_clr_i,
  input  logic                                 iret_i,
  output logic                                 req_o,
  output logic [vec_width(NUM_LINES)-1:0]      vec_o,
  output logic [NUM_LINES-1:0]                 en_o,
  output logic                                 mask_o,
  output logic [NUM_GROUPS-1:0]                ack_o
);

  localparam int unsigned VW      = vec_width(NUM_LINES);
  localparam int unsigned IW      = line_idx_width(NUM_LINES);
  localparam int unsigned FW      = NUM_LINES + 2;
  localparam logic [VW-1:0] NMI_VEC = VW'(NUM_LINES);

  // architectural state
  logic [NUM_LINES-1:0]  en_q;
  logic                  mask_q;
  logic [NUM_GROUPS-1:0] ack_q;
  logic                  nmi_act;

  // named internal events
  logic [NUM_LINES-1:0]  irq_pend;
  logic                  nmi_pend;
  logic [NUM_LINES-1:0]  grp_blk;
  logic [NUM_LINES-1:0]  eligible;
  logic                  m_any;
  logic [IW-1:0]         m_idx;
  logic [NUM_LINES-1:0]  m_grant;
  logic                  hold;
  logic                  take_n;
  logic                  take_m;
  logic                  pop;
  logic [FW-1:0]         stk_top;
  logic                  stk_empty;
  logic                  stk_full;
  stk_op_e               stk_op;

  irqc_edge_latch #(.N(NUM_LINES)) u_irq_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (irq_lvl_i),
    .arm  ({NUM_LINES{1'b1}}),
    .clr  (take_m ? m_grant : '0),
    .pend (irq_pend)
  );

  irqc_edge_latch #(.N(1)) u_nmi_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (nmi_lvl_i),
    .arm  (~nmi_act),
    .clr  (take_n),
    .pend (nmi_pend)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_gate
    if (g < NUM_GROUPS) begin : g_grp
      assign grp_blk[g] = ack_q[g];
    end else begin : g_free
      assign grp_blk[g] = 1'b0;
    end
  end

  assign eligible = irq_pend & en_q & ~grp_blk & {NUM_LINES{~mask_q}};

  irqc_select #(.N(NUM_LINES), .IW(IW)) u_select (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (eligible),
    .any  (m_any),
    .idx  (m_idx),
    .grant(m_grant)
  );

  assign hold   = iret_i | stk_full;
  assign take_n = nmi_pend & ~nmi_act & ~hold;
  assign take_m = m_any & ~take_n & ~hold;
  assign pop    = iret_i & ~stk_empty;
  assign stk_op = pop ? STK_POP : ((take_n | take_m) ? STK_PUSH : STK_IDLE);

  irqc_ctx_stack #(.W(FW), .DEPTH(STACK_DEPTH)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (stk_op),
    .wdata({en_q, mask_q, take_n}),
    .top  (stk_top),
    .empty(stk_empty),
    .full (stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= 1'b1;
      nmi_act <= 1'b0;
    end else if (pop) begin
      en_q   <= stk_top[FW-1:2];
      mask_q <= stk_top[1];
      if (stk_top[0]) nmi_act <= 1'b0;
    end else if (take_m) begin
      en_q   <= en_q & ~m_grant;
      mask_q <= 1'b1;
    end else if (take_n) begin
      nmi_act <= 1'b1;
    end else if (!iret_i) begin
      if (en_we_i)   en_q   <= en_wdata_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= (ack_q & ~ack_clr_i) | (take_m ? m_grant[NUM_GROUPS-1:0] : '0);
  end

  assign req_o  = take_n | take_m;
  assign vec_o  = take_n ? NMI_VEC : VW'(m_idx);
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign ack_o  = ack_q;

  assert_maskable_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && vec_o != NMI_VEC) |-> (!mask_q && en_q[m_idx]));

  assert_entry_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_m |=> (mask_q && ((en_q & $past(m_grant)) == '0)
                && ((ack_q & $past(m_grant[NUM_GROUPS-1:0])) == $past(m_grant[NUM_GROUPS-1:0]))));

  assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_m |-> ((m_grant[NUM_GROUPS-1:0] & ack_q) == '0));

  assert_nmi_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_act && !iret_i && !stk_full) |-> (req_o && vec_o == NMI_VEC));

  assert_nmi_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_n |=> (en_q == $past(en_q) && mask_q == $past(mask_q)));

  assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_act |-> !(req_o && vec_o == NMI_VEC));

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (en_q == $past(stk_top[FW-1:2]) && mask_q == $past(stk_top[1])));

  assert_quiet_on_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    iret_i |-> !req_o);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;
  localparam int NG = 12;
  localparam logic [NL-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_lvl = '0;
  logic          nmi_lvl = 1'b0;
  logic          en_we = 1'b0;
  logic [NL-1:0] en_wdata = '0;
  logic          mask_we = 1'b0;
  logic          mask_wdata = 1'b0;
  logic [NG-1:0] ack_clr = '0;
  logic          iret = 1'b0;
  logic          req;
  logic [4:0]    vec;
  logic [NL-1:0] en;
  logic          mask;
  logic [NG-1:0] ack;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl), .nmi_lvl_i(nmi_lvl),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wdata), .ack_clr_i(ack_clr), .iret_i(iret),
    .req_o(req), .vec_o(vec), .en_o(en), .mask_o(mask), .ack_o(ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance to the next cycle; one-shot inputs drop back
  task automatic nx();
    @(negedge clk);
    en_we = 1'b0; mask_we = 1'b0; ack_clr = '0; iret = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle();
    nx(); settle();
  endtask

  task automatic init_on();
    nx();
    en_we = 1'b1; en_wdata = ALL; mask_we = 1'b1; mask_wdata = 1'b0; ack_clr = '1;
    settle();
    idle();
  endtask

  // two-cycle edge; returns in the cycle where the request is visible
  task automatic pulse(input logic [NL-1:0] bits);
    nx(); irq_lvl = bits; settle();
    nx(); irq_lvl = '0; settle();
  endtask

  task automatic pulse_nmi();
    nx(); nmi_lvl = 1'b1; settle();
    nx(); nmi_lvl = 1'b0; settle();
  endtask

  task automatic do_iret();
    nx(); iret = 1'b1; settle();
    chk("R11 no request in return cycle", 32'(req), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R1 reset req", 32'(req), 32'd0);
    chk("R1 reset enable", 32'(en), 32'd0);
    chk("R1 reset mask", 32'(mask), 32'd1);
    chk("R1 reset gates", 32'(ack), 32'd0);

    // single-line entry/exit sweep
    for (int i = 0; i < NL; i++) begin
      init_on();
      pulse(NL'(1) << i);
      chk("R4 single vector", {27'd0, req, vec}, {27'd0, 1'b1, 5'(i)});
      idle();
      chk("R5 enable cleared", 32'(en), 32'(ALL & ~(NL'(1) << i)));
      chk("R5 mask set", 32'(mask), 32'd1);
      chk("R5 group gate", 32'(ack), (i < NG) ? 32'(NG'(1) << i) : 32'd0);
      chk("R11 strobe one cycle", 32'(req), 32'd0);
      do_iret();
      idle();
      chk("R10 enable restored", 32'(en), 32'(ALL));
      chk("R10 mask restored", 32'(mask), 32'd0);
      chk("R6 gate held after return", 32'(ack), (i < NG) ? 32'(NG'(1) << i) : 32'd0);
    end

    // pairwise priority sweep
    for (int i = 0; i < NL; i++) begin
      for (int j = i + 1; j < NL; j++) begin
        init_on();
        pulse((NL'(1) << i) | (NL'(1) << j));
        chk("R4 lowest wins", {27'd0, req, vec}, {27'd0, 1'b1, 5'(i)});
        idle();
        do_iret();
        idle();
        chk("R7 later line after return", {27'd0, req, vec}, {27'd0, 1'b1, 5'(j)});
        idle();
        do_iret();
        idle();
      end
    end

    // R2: held level does not re-trigger
    init_on();
    nx(); irq_lvl = NL'(1) << 14; settle();
    idle();
    chk("R2 level first request", {27'd0, req, vec}, {27'd0, 1'b1, 5'd14});
    idle();
    do_iret();
    idle();
    chk("R2 held level no retrigger", 32'(req), 32'd0);
    nx(); irq_lvl = '0; settle();

    // R2: two edges while pending give one request
    init_on();
    nx(); mask_we = 1'b1; mask_wdata = 1'b1; settle();
    pulse(NL'(1) << 14);
    pulse(NL'(1) << 14);
    chk("R3 masked no request", 32'(req), 32'd0);
    nx(); mask_we = 1'b1; mask_wdata = 1'b0; settle();
    idle();
    chk("R2 one request", {27'd0, req, vec}, {27'd0, 1'b1, 5'd14});
    idle();
    do_iret();
    idle();
    chk("R2 no second request", 32'(req), 32'd0);
    idle();
    chk("R2 still none", 32'(req), 32'd0);

    // R3: enable gating
    init_on();
    nx(); en_we = 1'b1; en_wdata = ALL & ~(NL'(1) << 5); settle();
    pulse(NL'(1) << 5);
    chk("R3 disabled no request", 32'(req), 32'd0);
    idle();
    chk("R3 disabled still none", 32'(req), 32'd0);
    nx(); en_we = 1'b1; en_wdata = ALL; settle();
    idle();
    chk("R3 fires once enabled", {27'd0, req, vec}, {27'd0, 1'b1, 5'd5});
    idle();
    do_iret();
    idle();

    // R6: group gate
    init_on();
    pulse(NL'(1) << 3);
    chk("R6 first take", {27'd0, req, vec}, {27'd0, 1'b1, 5'd3});
    idle();
    do_iret();
    idle();
    pulse(NL'(1) << 3);
    chk("R6 gate blocks own line", 32'(req), 32'd0);
    idle();
    chk("R6 gate still blocks", 32'(req), 32'd0);
    pulse(NL'(1) << 5);
    chk("R6 other group passes", {27'd0, req, vec}, {27'd0, 1'b1, 5'd5});
    idle();
    do_iret();
    nx(); ack_clr = NG'(1) << 3; settle();
    chk("R6 blocked before clear lands", 32'(req), 32'd0);
    idle();
    chk("R6 released by clear", {27'd0, req, vec}, {27'd0, 1'b1, 5'd3});
    idle();
    do_iret();
    idle();
    pulse(NL'(1) << 13);
    chk("R6 ungated line first", {27'd0, req, vec}, {27'd0, 1'b1, 5'd13});
    idle();
    do_iret();
    idle();
    pulse(NL'(1) << 13);
    chk("R6 ungated line again", {27'd0, req, vec}, {27'd0, 1'b1, 5'd13});
    idle();
    do_iret();
    idle();

    // R7: no preemption by a lower-numbered line
    init_on();
    pulse(NL'(1) << 8);
    chk("R7 handler entry", {27'd0, req, vec}, {27'd0, 1'b1, 5'd8});
    idle();
    pulse(NL'(1) << 2);
    chk("R7 no preemption", 32'(req), 32'd0);
    idle();
    chk("R7 still pending", 32'(req), 32'd0);
    do_iret();
    idle();
    chk("R7 taken after return", {27'd0, req, vec}, {27'd0, 1'b1, 5'd2});
    idle();
    do_iret();
    idle();

    // R8, R9, R10, R11: NMI preemption and full stack
    init_on();
    pulse(NL'(1) << 6);
    chk("R8 maskable entry", {27'd0, req, vec}, {27'd0, 1'b1, 5'd6});
    idle();
    pulse_nmi();
    chk("R8 nmi preempts", {27'd0, req, vec}, {27'd0, 1'b1, 5'd16});
    idle();
    chk("R8 enable unchanged", 32'(en), 32'(ALL & ~(NL'(1) << 6)));
    chk("R8 mask unchanged", 32'(mask), 32'd1);
    nx(); en_we = 1'b1; en_wdata = ALL; mask_we = 1'b1; mask_wdata = 1'b0; settle();
    pulse(NL'(1) << 1);
    chk("R11 full stack holds request", 32'(req), 32'd0);
    pulse_nmi();
    chk("R9 second nmi ignored", 32'(req), 32'd0);
    do_iret();
    idle();
    chk("R10 nmi frame enable", 32'(en), 32'(ALL & ~(NL'(1) << 6)));
    chk("R10 nmi frame mask", 32'(mask), 32'd1);
    chk("R9 no replayed nmi", 32'(req), 32'd0);
    do_iret();
    idle();
    chk("R10 outer frame mask", 32'(mask), 32'd0);
    chk("R7 held line after unwind", {27'd0, req, vec}, {27'd0, 1'b1, 5'd1});
    idle();
    do_iret();
    idle();
    pulse_nmi();
    chk("R8 nmi with gates open", {27'd0, req, vec}, {27'd0, 1'b1, 5'd16});
    idle();
    do_iret();
    idle();

    // R8: nmi while fully masked and disabled
    nx(); en_we = 1'b1; en_wdata = '0; mask_we = 1'b1; mask_wdata = 1'b1; settle();
    pulse_nmi();
    chk("R8 nmi ignores mask and enable", {27'd0, req, vec}, {27'd0, 1'b1, 5'd16});
    idle();
    do_iret();
    idle();
    chk("R10 enable after nmi return", 32'(en), 32'd0);

    // R10: return with empty stack
    init_on();
    do_iret();
    idle();
    chk("R10 empty return enable", 32'(en), 32'(ALL));
    chk("R10 empty return mask", 32'(mask), 32'd0);

    // R11: writes ignored during take
    init_on();
    nx(); irq_lvl = NL'(1) << 4; settle();
    nx(); irq_lvl = '0; en_we = 1'b1; en_wdata = '0; mask_we = 1'b1; mask_wdata = 1'b0; settle();
    chk("R11 vector with strobe", {27'd0, req, vec}, {27'd0, 1'b1, 5'd4});
    idle();
    chk("R11 write ignored enable", 32'(en), 32'(ALL & ~(NL'(1) << 4)));
    chk("R11 write ignored mask", 32'(mask), 32'd1);
    do_iret();
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule